// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block sits between a processor core and a small peripheral address space of 2048 locations. When the core starts a read or write toward that space, the block registers the address and the direction strobe, raises a peripheral select and holds it for a programmable number of stall cycles. It then signals completion with a one-cycle ready pulse. The stall length is not global. The space is split into four equal windows of 512 locations, and each window has its own 3-bit stall setting. The two most significant bits of the 11-bit address choose which setting applies.

The stall settings live in four small configuration registers. A write port updates them one at a time. All four are visible together on a flat output bus, so the core or a debugger can read them back. The setting for an access is sampled in the cycle the access is accepted. Rewriting a register during an access therefore leaves that access unchanged.

Top module: `io_wait_gen`

## Requirements
- R1: Out of synchronous reset, `io_sel`, `io_ready`, `io_rd` and `io_wr` are 0, and all four stall fields of `wait_cfg` read 7.
- R2: An access is accepted at a clock edge only when `acc_start` is 1, the block is idle (`io_sel` is 0), and exactly one of `acc_rd` and `acc_wr` is 1. A start with both strobes high or both low raises no select.
- R3: Address bits [10:9] pick the stall field: value 0 picks field 0 (addresses 0x000–0x1FF), 1 picks field 1 (0x200–0x3FF), 2 picks field 2 (0x400–0x5FF) and 3 picks field 3 (0x600–0x7FF).
- R4: With a selected stall value W, `io_sel` is 1 from the first cycle after the accepting edge for exactly W+1 consecutive cycles.
- R5: `io_ready` is 1 only in the last of those W+1 cycles (so it is high in the first cycle when W=0), and `io_sel` is 0 in the cycle after `io_ready`.
- R6: While `io_sel` is 1, `io_addr` equals the accepted address, and `io_rd`/`io_wr` equal the accepted strobes.
- R7: The stall value is captured at the accepting edge. A configuration write to the selected field during the access does not change that access's length.
- R8: When `cfg_we` is 1 at an edge, field `cfg_idx` takes `cfg_wdata`, and the new value appears on `wait_cfg[3*i+2:3*i]` for field i after that edge. The other fields keep their values.
- R9: A start seen while an access is in progress, including its ready cycle, is ignored. No second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | Access request pulse from the core |
| acc_rd | input | 1 | Read strobe of the request |
| acc_wr | input | 1 | Write strobe of the request |
| acc_addr | input | 11 | I/O location of the request |
| cfg_we | input | 1 | Stall-setting write enable |
| cfg_idx | input | 2 | Which stall field to write |
| cfg_wdata | input | 3 | New stall value |
| wait_cfg | output | 12 | All four stall fields, field i at bits 3i+2:3i |
| io_sel | output | 1 | Peripheral select, high for the whole access |
| io_rd | output | 1 | Registered read strobe toward the peripheral |
| io_wr | output | 1 | Registered write strobe toward the peripheral |
| io_addr | output | 11 | Registered address toward the peripheral |
| io_ready | output | 1 | Completion pulse to the core; low means stall |

## Verification
Every output is a register, so the select and strobes first show in the cycle after the edge that samples `acc_start`. The ready pulse comes W cycles after the select rises, and the select falls one cycle after ready. A configuration write shows on `wait_cfg` in the cycle after its edge. The bench drives and samples only on falling edges. It counts, cycle by cycle from the first select cycle, how many cycles the select stays high and in which of them ready appears. It then compares that count with W+1 and the ready position with W, both computed from the values the bench itself wrote.

// File: rtl/iow_pkg.sv
package iow_pkg;

  // sequencer phase
  typedef enum logic [0:0] {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_t;

  // accepted request
  typedef struct packed {
    logic [10:0] addr;
    logic        rd;
    logic        wr;
  } io_req_t;

endpackage

// File: rtl/iow_cfg_regs.sv
module iow_cfg_regs #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  parameter int RESET_WAIT  = 7,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [WAIT_W-1:0]             wdata,
  output logic [NUM_REGIONS*WAIT_W-1:0] flat
);

  logic [WAIT_W-1:0] regs [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= WAIT_W'(RESET_WAIT);
      else if (we && (idx == IDX_W'(g)))
        regs[g] <= wdata;
    end
    assign flat[g*WAIT_W +: WAIT_W] = regs[g];
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(idx)] == $past(wdata))); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat)); // R8

endmodule

// File: rtl/iow_region_decode.sv
module iow_region_decode #(
  parameter int ADDR_W      = 11,
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_REGIONS*WAIT_W-1:0] cfg,
  output logic [IDX_W-1:0]              region,
  output logic [WAIT_W-1:0]             wait_val
);

  assign region = addr[ADDR_W-1 -: IDX_W];

  always_comb begin
    wait_val = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (region == IDX_W'(i))
        wait_val = cfg[i*WAIT_W +: WAIT_W];
  end

endmodule

// File: rtl/iow_seq.sv
module iow_seq
  import iow_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  io_req_t           req,
  input  logic [WAIT_W-1:0] req_wait,
  output logic              sel,
  output logic              ready,
  output io_req_t           cur
);

  phase_t            phase;
  logic [WAIT_W-1:0] cnt;
  logic              accept;

  assign accept = start && (req.rd ^ req.wr) && (phase == PH_IDLE);
  assign sel    = (phase == PH_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ready <= 1'b0;
      cur   <= '0;
    end else if (accept) begin
      phase <= PH_ACTIVE;
      cnt   <= req_wait;
      ready <= (req_wait == '0);
      cur   <= req;
    end else if (phase == PH_ACTIVE) begin
      if (ready) begin
        phase  <= PH_IDLE;
        ready  <= 1'b0;
        cur.rd <= 1'b0;
        cur.wr <= 1'b0;
      end else begin
        cnt   <= cnt - 1'b1;
        ready <= (cnt == WAIT_W'(1));
      end
    end
  end

  AST_READY_IN_SEL: assert property (@(posedge clk) disable iff (rst)
    ready |-> sel); // R5

  AST_SEL_DROP: assert property (@(posedge clk) disable iff (rst)
    ready |=> !sel); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sel && !ready) |=> (sel && $stable(cur))); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (sel && !ready && start) |=> $stable(cur)); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    sel |-> (cur.rd ^ cur.wr)); // R2

endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
  import iow_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  parameter int RESET_WAIT  = 7,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int CFG_W      = NUM_REGIONS * WAIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_start,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WAIT_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0]  wait_cfg,
  output logic              io_sel,
  output logic              io_rd,
  output logic              io_wr,
  output logic [ADDR_W-1:0] io_addr,
  output logic              io_ready
);

  logic [IDX_W-1:0]  region;
  logic [WAIT_W-1:0] sel_wait;
  io_req_t           req, cur;

  assign req.addr = acc_addr;
  assign req.rd   = acc_rd;
  assign req.wr   = acc_wr;

  iow_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W), .RESET_WAIT(RESET_WAIT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata), .flat(wait_cfg)
  );

  iow_region_decode #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_dec (
    .addr(acc_addr), .cfg(wait_cfg), .region(region), .wait_val(sel_wait)
  );

  iow_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst(rst), .start(acc_start), .req(req), .req_wait(sel_wait),
    .sel(io_sel), .ready(io_ready), .cur(cur)
  );

  assign io_addr = cur.addr;
  assign io_rd   = cur.rd;
  assign io_wr   = cur.wr;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!io_sel && !(acc_start && (acc_rd ^ acc_wr))) |=> !io_sel); // R2

  AST_SEL_ON_START: assert property (@(posedge clk) disable iff (rst)
    (!io_sel && acc_start && (acc_rd ^ acc_wr)) |=> (io_sel && io_addr == $past(acc_addr))); // R4

  AST_REGION_RANGE: assert property (@(posedge clk) disable iff (rst)
    (region == acc_addr[ADDR_W-1 -: IDX_W])); // R3

endmodule

// File: tb/io_wait_gen_test.sv
module io_wait_gen_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_start, acc_rd, acc_wr;
  logic [10:0] acc_addr;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [2:0]  cfg_wdata;
  logic [11:0] wait_cfg;
  logic        io_sel, io_rd, io_wr, io_ready;
  logic [10:0] io_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  io_wait_gen uut (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .wait_cfg(wait_cfg), .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_ready(io_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [2:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(wait_cfg[idx*3 +: 3] == val, "R8 field written", wait_cfg[idx*3 +: 3], val);
  endtask

  // one access; measures select length and ready position
  task automatic do_access(input logic [10:0] addr, input bit rd, input int expw,
                           input bit hold, input bit midwr, input logic [1:0] widx,
                           input logic [2:0] wval, input string tag);
    int k;
    int rdy_at;
    bit addr_ok;
    bit strb_ok;
    k = 0; rdy_at = -1; addr_ok = 1'b1; strb_ok = 1'b1;
    @(negedge clk);
    acc_addr = addr; acc_rd = rd; acc_wr = ~rd; acc_start = 1'b1;
    @(negedge clk);
    if (!hold) acc_start = 1'b0;
    while (io_sel && k < 12) begin
      if (io_ready) rdy_at = k;
      if (io_addr != addr) addr_ok = 1'b0;
      if (io_rd != rd || io_wr != ~rd) strb_ok = 1'b0;
      cfg_we = midwr && (k == 0);
      cfg_idx = widx; cfg_wdata = wval;
      @(negedge clk);
      k++;
    end
    cfg_we = 1'b0;
    chk(k == expw + 1, {tag, " R4 select length"}, k, expw + 1);
    chk(rdy_at == expw, {tag, " R5 ready position"}, rdy_at, expw);
    chk(addr_ok && strb_ok, {tag, " R6 addr/strobes held"}, int'(io_addr), int'(addr));
    chk(!io_sel, {tag, " R5/R9 select low after ready"}, io_sel, 0);
    acc_start = 1'b0;
    @(negedge clk);
    chk(!io_sel, {tag, " R9 no second access"}, io_sel, 0);
  endtask

  task automatic t_reset();
    chk(!io_sel && !io_ready && !io_rd && !io_wr, "R1 outputs idle", io_sel, 0);
    chk(wait_cfg == 12'o7777, "R1 fields at 7", wait_cfg, 12'o7777);
    do_access(11'h123, 1'b1, 7, 1'b0, 1'b0, 2'd0, 3'd0, "R1 default wait");
  endtask

  task automatic t_regions();
    cfg_write(2'd0, 3'd0);
    cfg_write(2'd1, 3'd3);
    cfg_write(2'd2, 3'd5);
    cfg_write(2'd3, 3'd1);
    chk(wait_cfg == {3'd1, 3'd5, 3'd3, 3'd0}, "R8 others kept", wait_cfg, {3'd1, 3'd5, 3'd3, 3'd0});
    do_access(11'h000, 1'b1, 0, 1'b0, 1'b0, 2'd0, 3'd0, "R3 region0 low");
    do_access(11'h1FF, 1'b0, 0, 1'b0, 1'b0, 2'd0, 3'd0, "R3 region0 high");
    do_access(11'h200, 1'b0, 3, 1'b0, 1'b0, 2'd0, 3'd0, "R3 region1");
    do_access(11'h5FF, 1'b1, 5, 1'b0, 1'b0, 2'd0, 3'd0, "R3 region2");
    do_access(11'h600, 1'b1, 1, 1'b0, 1'b0, 2'd0, 3'd0, "R3 region3");
  endtask

  task automatic t_bad_strobes();
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    acc_addr = 11'h300; acc_rd = 1'b1; acc_wr = 1'b1; acc_start = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (io_sel) seen = 1'b1;
      @(negedge clk);
    end
    acc_start = 1'b0;
    if (io_sel) seen = 1'b1;
    chk(!seen, "R2 bad strobes ignored", seen, 0);
  endtask

  task automatic t_midwrite();
    do_access(11'h2AA, 1'b1, 3, 1'b0, 1'b1, 2'd1, 3'd6, "R7 write during access");
    chk(wait_cfg[5:3] == 3'd6, "R7 write landed", wait_cfg[5:3], 6);
    do_access(11'h2AA, 1'b0, 6, 1'b0, 1'b0, 2'd0, 3'd0, "R7 next access new value");
  endtask

  task automatic t_busy();
    do_access(11'h7F0, 1'b0, 1, 1'b1, 1'b0, 2'd0, 3'd0, "R9 start held w1");
    do_access(11'h010, 1'b1, 0, 1'b1, 1'b0, 2'd0, 3'd0, "R9 start held w0");
  endtask

  initial begin
    rst = 1'b1; acc_start = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regions();
    t_bad_strobes();
    t_midwrite();
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule